// File: doc/BRIEF.md
# Serial Register Slave (Clock-Mode 3, 3/4-Wire)

This block lets an external serial master read and write a small map of byte-wide registers over a clock-mode-3 serial link. The serial clock idles high while the select line is high. The block launches data on the falling edge and samples on the rising edge. All three inbound serial lines are brought into a fast system clock through a multi-stage synchronizer. The engine then runs on the detected clock edges, so the serial clock may run at up to 10 MHz while the system clock is 125 MHz. Each frame opens with one command byte. That byte carries the direction, an auto-increment flag and a 6-bit register address. Any number of data bytes then follow, most significant bit first, until the select line rises.

The register contents live outside the block. The block presents a combinational read port (address out, data in) and a write stream (valid, address and data). The write stream carries no ready signal, because a serial master cannot be stalled. The register owner must accept a write in the cycle it is offered. Writes are spaced at least eight serial clocks apart. The block holds the identification value at address 0 itself. It also filters out writes to addresses that software may not change.

Read data leaves on a dedicated output pin in 4-wire mode. In 3-wire mode it leaves on the shared data pin. The mode is chosen at run time by a plain input from the surrounding configuration logic.

Top module: `spi_regslave`

## Requirements
- R1: The serial clock idles high while select is high; the block samples inbound data on the rising edge of the serial clock and changes outbound data only after a falling edge, so a master sampling on the rising edge always sees settled data at a serial clock period of 100 ns or more.
- R2: The first byte after select falls is the command, sent MSb first: bit 7 is the direction (1 = read, 0 = write), bit 6 is the auto-increment flag, and bits 5:0 are the starting address.
- R3: In a write frame, each complete data byte (MSb first) produces exactly one single-cycle `rf_wr_valid` pulse carrying the current address and the byte.
- R4: In a read frame, the block drives the first data bit from the falling edge that opens bit 8 of the frame, MSb first, and a new byte from every eighth falling edge after that.
- R5: With the auto-increment flag at 1, the address advances by one after every data byte and wraps from 63 to 0; with the flag at 0, every data byte of the frame uses the starting address.
- R6: A frame may carry any number of data bytes; it ends only when select rises.
- R7: With `three_wire` = 0, read data is driven on `spi_sdo_o` and `spi_sio_oe` stays low. With `three_wire` = 1, read data is driven on the shared pin `spi_sio_o` and `spi_sdo_oe` stays low.
- R8: Address 0x00 always reads 0xDA and cannot be written.
- R9: Only addresses 0x0B through 0x10 are writable; a write byte aimed at any other address produces no `rf_wr_valid` pulse.
- R10: Addresses 0x01 through 0x10 return `rf_rd_data` for the address presented on `rf_rd_addr`; addresses 0x11 through 0x3F read as 0x00.
- R11: Both output enables are low while select is high and throughout the command byte.
- R12: If select rises before a byte is complete, that byte is dropped with no write, and the next frame starts again with a command byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| three_wire | input | 1 | 1 selects shared-pin (3-wire) read return, 0 selects separate output pin |
| spi_sck | input | 1 | Serial clock from master, idles high |
| spi_csn | input | 1 | Active-low select from master |
| spi_sio_i | input | 1 | Data pin input (command and write data; shared pin in 3-wire mode) |
| spi_sio_o | output | 1 | Shared data pin output value |
| spi_sio_oe | output | 1 | Shared data pin drive enable |
| spi_sdo_o | output | 1 | Separate read data output value |
| spi_sdo_oe | output | 1 | Separate read data output drive enable |
| rf_rd_addr | output | 6 | Address of the register being fetched for read |
| rf_rd_data | input | 8 | Combinational read data for `rf_rd_addr` |
| rf_wr_valid | output | 1 | Single-cycle write strobe, no back-pressure |
| rf_wr_addr | output | 6 | Write address, valid with the strobe |
| rf_wr_data | output | 8 | Write data, valid with the strobe |

## Verification
The bench runs bursts that cross the edges of the writable window and reads that wrap the address from 63 to 0. A block that clipped or mis-decoded the window would emit a write to 0x11, or would fail to write 0x10. A block that mishandled the wrap would return the wrong byte after 0x3F. Non-incrementing bursts are checked to make sure that a design which advanced the address anyway is caught, because its writes would land in neighbouring registers. A frame cut off after four data bits must leave no write behind, and the frame that follows must still work. This exposes a design that commits partial shift contents or keeps a stale bit count. Both interface modes are read back while the idle enable is watched. A design that drove the wrong pin, or drove during the command byte, would corrupt the line or the sampled data.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;
  // frame position: command byte, then write or read data bytes
  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WDATA = 2'd1,
    PH_RDATA = 2'd2
  } frame_phase_e;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_addr_map.sv
module spi_addr_map #(
  parameter int                DATA_W   = 8,
  parameter int                ADDR_W   = 6,
  parameter logic [DATA_W-1:0] ID_VALUE = 8'hDA,
  parameter logic [ADDR_W-1:0] WR_LO    = 6'h0B,
  parameter logic [ADDR_W-1:0] WR_HI    = 6'h10,
  parameter logic [ADDR_W-1:0] RD_HI    = 6'h10
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] ext_data,
  output logic [DATA_W-1:0] rd_byte,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              wr_ok
);
  always_comb begin
    if (rd_addr == '0)          rd_byte = ID_VALUE;
    else if (rd_addr <= RD_HI)  rd_byte = ext_data;
    else                        rd_byte = '0;
  end

  assign wr_ok = (wr_addr >= WR_LO) && (wr_addr <= WR_HI);
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_regslave_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 2,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_byte,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              wr_cand,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              tx_bit,
  output logic              drive
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic              sck_q;
  logic              sck_rise, sck_fall;
  frame_phase_e      phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-2:0] rx_sh;
  logic [DATA_W-1:0] rx_byte;
  logic [DATA_W-1:0] tx_sh;
  logic              inc_q;
  logic [ADDR_W-1:0] addr_q;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign rx_byte  = {rx_sh, sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b1;
      phase   <= PH_CMD;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      inc_q   <= 1'b0;
      addr_q  <= '0;
      drive   <= 1'b0;
      wr_cand <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      sck_q   <= sck_s;
      wr_cand <= 1'b0;
      if (csn_s) begin
        // idle or aborted frame: forget any partial byte
        phase   <= PH_CMD;
        bit_cnt <= '0;
        drive   <= 1'b0;
      end else begin
        if (sck_rise) begin
          rx_sh   <= rx_byte[DATA_W-2:0];
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == LAST_BIT) begin
            case (phase)
              PH_CMD: begin
                inc_q  <= rx_byte[DATA_W-2];
                addr_q <= rx_byte[ADDR_W-1:0];
                phase  <= rx_byte[DATA_W-1] ? PH_RDATA : PH_WDATA;
              end
              PH_WDATA: begin
                wr_cand <= 1'b1;
                wr_addr <= addr_q;
                wr_data <= rx_byte;
                if (inc_q) addr_q <= addr_q + 1'b1;
              end
              PH_RDATA: begin
                if (inc_q) addr_q <= addr_q + 1'b1;
              end
              default: phase <= PH_CMD;
            endcase
          end
        end
        if (sck_fall && phase == PH_RDATA) begin
          drive <= 1'b1;
          if (bit_cnt == '0) tx_sh <= rd_byte;
          else               tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign cur_addr = addr_q;
  assign tx_bit   = tx_sh[DATA_W-1];
endmodule

// File: rtl/spi_regslave.sv
module spi_regslave #(
  parameter int                DATA_W      = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] ID_VALUE    = 8'hDA,
  parameter logic [5:0]        WR_LO       = 6'h0B,
  parameter logic [5:0]        WR_HI       = 6'h10,
  parameter logic [5:0]        RD_HI       = 6'h10,
  localparam int               ADDR_W      = DATA_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              three_wire,
  input  logic              spi_sck,
  input  logic              spi_csn,
  input  logic              spi_sio_i,
  output logic              spi_sio_o,
  output logic              spi_sio_oe,
  output logic              spi_sdo_o,
  output logic              spi_sdo_oe,
  output logic [ADDR_W-1:0] rf_rd_addr,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_wr_valid,
  output logic [ADDR_W-1:0] rf_wr_addr,
  output logic [DATA_W-1:0] rf_wr_data
);
  logic              csn_s, sck_s, sdi_s;
  logic [DATA_W-1:0] rd_byte;
  logic [ADDR_W-1:0] cur_addr;
  logic              wr_cand, wr_ok;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              tx_bit, drive;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_csn, spi_sck, spi_sio_i}),
    .q     ({csn_s, sck_s, sdi_s})
  );

  spi_frame #(.DATA_W(DATA_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_s    (sck_s),
    .csn_s    (csn_s),
    .sdi_s    (sdi_s),
    .rd_byte  (rd_byte),
    .cur_addr (cur_addr),
    .wr_cand  (wr_cand),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .tx_bit   (tx_bit),
    .drive    (drive)
  );

  spi_addr_map #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_VALUE(ID_VALUE),
    .WR_LO(WR_LO), .WR_HI(WR_HI), .RD_HI(RD_HI)
  ) u_map (
    .rd_addr  (cur_addr),
    .ext_data (rf_rd_data),
    .rd_byte  (rd_byte),
    .wr_addr  (wr_addr),
    .wr_ok    (wr_ok)
  );

  assign rf_rd_addr  = cur_addr;
  assign rf_wr_valid = wr_cand & wr_ok;
  assign rf_wr_addr  = wr_addr;
  assign rf_wr_data  = wr_data;

  assign spi_sio_o   = tx_bit;
  assign spi_sdo_o   = tx_bit;
  assign spi_sio_oe  = drive & three_wire;
  assign spi_sdo_oe  = drive & ~three_wire;
endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk #(
  parameter int         ADDR_W = 6,
  parameter logic [5:0] WR_LO  = 6'h0B,
  parameter logic [5:0] WR_HI  = 6'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              three_wire,
  input logic              spi_csn,
  input logic              spi_sio_oe,
  input logic              spi_sdo_oe,
  input logic              rf_wr_valid,
  input logic [ADDR_W-1:0] rf_wr_addr
);
  // select held high for three cycles: both drivers released
  assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_csn && $past(spi_csn) && $past(spi_csn, 2) && $past(spi_csn, 3))
      |-> !(spi_sio_oe || spi_sdo_oe));

  assert_sdo_quiet_3w_R7: assert property (@(posedge clk) disable iff (!rst_n)
    three_wire |-> !spi_sdo_oe);

  assert_sio_quiet_4w_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !three_wire |-> !spi_sio_oe);

  assert_wr_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_valid |-> (rf_wr_addr >= WR_LO && rf_wr_addr <= WR_HI));

  assert_wr_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_valid |=> !rf_wr_valid);

  assert_one_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({spi_sio_oe, spi_sdo_oe}));
endmodule

bind spi_regslave spi_regslave_chk #(.ADDR_W(ADDR_W), .WR_LO(WR_LO), .WR_HI(WR_HI)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .three_wire  (three_wire),
  .spi_csn     (spi_csn),
  .spi_sio_oe  (spi_sio_oe),
  .spi_sdo_oe  (spi_sdo_oe),
  .rf_wr_valid (rf_wr_valid),
  .rf_wr_addr  (rf_wr_addr)
);

// File: tb/tb_spi_regslave.sv
`timescale 1ns/1ps
module tb_spi_regslave;
  localparam int HALF = 56;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       three_wire = 1'b0;
  logic       spi_sck = 1'b1;
  logic       spi_csn = 1'b1;
  logic       tb_drv = 1'b0;
  logic       tb_drv_en = 1'b1;
  logic       spi_sio_o, spi_sio_oe, spi_sdo_o, spi_sdo_oe;
  logic [5:0] rf_rd_addr;
  logic [7:0] rf_rd_data;
  logic       rf_wr_valid;
  logic [5:0] rf_wr_addr;
  logic [7:0] rf_wr_data;
  logic       sio_line;

  logic [7:0]  regs [64];
  logic [7:0]  wbuf [8];
  logic [7:0]  rbuf [8];
  logic [13:0] exp_q [$];
  int n_checks = 0;
  int n_fail = 0;
  int cmd_oe_hits;
  int rd_oe_miss;
  bit done = 0;

  always #4 clk = ~clk;

  assign sio_line   = spi_sio_oe ? spi_sio_o : (tb_drv_en ? tb_drv : 1'b0);
  assign rf_rd_data = regs[rf_rd_addr];

  spi_regslave dut (
    .clk(clk), .rst_n(rst_n), .three_wire(three_wire),
    .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_sio_i(sio_line),
    .spi_sio_o(spi_sio_o), .spi_sio_oe(spi_sio_oe),
    .spi_sdo_o(spi_sdo_o), .spi_sdo_oe(spi_sdo_oe),
    .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .rf_wr_valid(rf_wr_valid), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [5:0] a);
    if (a == 6'h00)      return 8'hDA;
    else if (a <= 6'h10) return regs[a];
    else                 return 8'h00;
  endfunction

  function automatic logic [5:0] step(input logic [5:0] a, input bit inc, input int k);
    return inc ? 6'(a + k) : a;
  endfunction

  // monitor: pops expected writes as the design emits them
  always @(negedge clk) begin
    if (rst_n && rf_wr_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R9/R12 unexpected write actual=%0h:%0h expected=none", rf_wr_addr, rf_wr_data);
      end else begin
        chk("R3 write item", {rf_wr_addr, rf_wr_data}, {18'd0, exp_q.pop_front()});
      end
      regs[rf_wr_addr] = rf_wr_data;
    end
  end

  // one frame; cut_bits > 0 ends it early (abort)
  task automatic xfer(input logic [7:0] cmd, input int nbytes, input int cut_bits);
    int total;
    total = (cut_bits > 0) ? cut_bits : 8 + 8 * nbytes;
    cmd_oe_hits = 0;
    rd_oe_miss  = 0;
    @(posedge clk); #2;
    spi_csn = 1'b0;
    #HALF;
    for (int i = 0; i < total; i++) begin
      int b;
      b = i / 8 - 1;
      spi_sck = 1'b0;
      if (i < 8) begin
        tb_drv_en = 1'b1; tb_drv = cmd[7 - i];
      end else if (!cmd[7]) begin
        tb_drv_en = 1'b1; tb_drv = wbuf[b][7 - (i % 8)];
      end else begin
        tb_drv_en = 1'b0;
      end
      #HALF;
      spi_sck = 1'b1;
      if (i < 8 && (spi_sio_oe || spi_sdo_oe)) cmd_oe_hits++;
      if (i >= 8 && cmd[7]) begin
        rbuf[b][7 - (i % 8)] = three_wire ? spi_sio_o : spi_sdo_o;
        if (!(three_wire ? spi_sio_oe : spi_sdo_oe)) rd_oe_miss++;
      end
      #HALF;
    end
    spi_csn   = 1'b1;
    tb_drv_en = 1'b1;
    #(4 * HALF);
  endtask

  task automatic wr_burst(input logic [5:0] a, input bit inc, input int n);
    for (int k = 0; k < n; k++) begin
      logic [5:0] ak;
      ak = step(a, inc, k);
      if (ak >= 6'h0B && ak <= 6'h10) exp_q.push_back({ak, wbuf[k]});
    end
    xfer({1'b0, inc, a}, n, 0);
    chk("R3 all expected writes seen", exp_q.size(), 0);
  endtask

  task automatic rd_burst(input logic [5:0] a, input bit inc, input int n, input string req);
    xfer({1'b1, inc, a}, n, 0);
    for (int k = 0; k < n; k++) chk(req, rbuf[k], exp_rd(step(a, inc, k)));
    chk("R11 no drive in command byte", cmd_oe_hits, 0);
    chk("R4 drive during read data", rd_oe_miss, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) regs[i] = 8'(i * 7 + 1);
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 reset enables", {spi_sio_oe, spi_sdo_oe}, 0);
    chk("R3 reset write strobe", rf_wr_valid, 0);

    // ID read, 4-wire, at about 8.9 MHz serial clock
    rd_burst(6'h00, 1'b0, 1, "R8 R1 R2 id read");

    // single write then read back
    wbuf[0] = 8'h5A;
    wr_burst(6'h0B, 1'b0, 1);
    rd_burst(6'h0B, 1'b0, 1, "R10 R3 readback");

    // incrementing burst write and read
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
    wr_burst(6'h0E, 1'b1, 3);
    rd_burst(6'h0D, 1'b1, 4, "R5 R6 incrementing read");

    // non-incrementing burst write and read
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_burst(6'h0C, 1'b0, 3);
    chk("R5 fixed address last byte wins", regs[6'h0C], 8'h33);
    rd_burst(6'h0C, 1'b0, 2, "R5 fixed-address read");

    // writes to read-only and unmapped addresses
    wbuf[0] = 8'hEE;
    wr_burst(6'h00, 1'b0, 1);
    wr_burst(6'h03, 1'b0, 1);
    wr_burst(6'h20, 1'b0, 1);
    rd_burst(6'h00, 1'b0, 1, "R8 id unchanged");
    rd_burst(6'h03, 1'b0, 1, "R9 read-only unchanged");
    rd_burst(6'h20, 1'b0, 1, "R10 unmapped reads zero");

    // burst across the top of the writable window
    wbuf[0] = 8'h71; wbuf[1] = 8'h72; wbuf[2] = 8'h73;
    wr_burst(6'h0F, 1'b1, 3);
    chk("R9 top of window written", regs[6'h10], 8'h72);

    // address wrap 63 -> 0
    rd_burst(6'h3F, 1'b1, 2, "R5 wrap read");

    // 3-wire mode
    three_wire = 1'b1;
    rd_burst(6'h0B, 1'b0, 1, "R7 3-wire read");
    rd_burst(6'h0E, 1'b1, 2, "R7 3-wire burst");
    three_wire = 1'b0;
    rd_burst(6'h0B, 1'b0, 1, "R7 back to 4-wire");

    // abort mid-byte: no write committed
    wbuf[0] = 8'hFF;
    xfer(8'h0D, 1, 12);
    chk("R12 aborted byte not written", exp_q.size(), 0);
    rd_burst(6'h0D, 1'b0, 1, "R12 register unchanged after abort");
    wbuf[0] = 8'h77;
    wr_burst(6'h0D, 1'b0, 1);
    rd_burst(6'h0D, 1'b0, 1, "R12 next frame clean");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule